// File: doc/BRIEF.md
# Cross-Core Doorbell Interrupt Unit

This block lets any core of an N-core cluster ring an interrupt on any other core. It holds a pending matrix with one flop for each (receiver, sender) pair. Each core has one interrupt line, which is the OR of that core's row, so several senders aimed at one receiver share a single line. The receiver must still release every sender on its own.

Commands arrive on NP parallel command ports, one command per port per cycle. Each command carries an operation code, a core index and the index of the issuing core. Every command takes effect in one cycle. A read-type command returns its answer on that port's readback bus in the next cycle. The readback shows the matrix as it stood in the cycle the command was issued.

Top module: `xcore_doorbell`

## Requirements
- R1: A raise command (op 0) whose target index equals the issuing core index changes no pending bit and no interrupt line.
- R2: A raise command (op 0) from core s to core r with r different from s sets pending bit (r, s). The interrupt line of core r is high in the cycle after the command.
- R3: A peek command (op 1) with target r makes the port's readback equal to 1 in the next cycle if core r had any sender pending in the command cycle, and 0 if it had none. All upper bits are 0.
- R4: A who command (op 2) from core r makes the port's readback, in the next cycle, a bitmask in which bit s is set exactly when sender s was pending on core r in the command cycle.
- R5: A clear command (op 3) from core r with index s clears only pending bit (r, s).
- R6: Interrupt line r is high exactly while at least one sender is pending on core r. It stays high until every pending sender has been cleared.
- R7: Raising a bit that is already pending leaves the whole matrix unchanged.
- R8: When a raise and a clear address the same pending bit in the same cycle, the bit is pending afterwards.
- R9: After reset, all pending bits, interrupt lines and readbacks are 0. A port's readback keeps its value in every cycle after which that port issued no peek or who command.
- R10: Commands on different ports in the same cycle all take effect. Two senders raising one receiver give one asserted line and a two-bit who result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | NP | Per-port command strobe |
| cmd_op | input | 2*NP | Per-port operation: 0 raise, 1 peek, 2 who, 3 clear |
| cmd_idx | input | IW*NP | Per-port target core (raise, peek) or sender (clear) |
| cmd_src | input | IW*NP | Per-port index of the issuing core |
| rdata | output | N*NP | Per-port registered readback |
| irq_out | output | N | One interrupt line per core |

## Verification
The assertions assume that every index driven on a valid port is below N. With the default N of 4 this holds for any index value. They do not assume that ports avoid each other: the stimulus freely sends raises and clears to the same bit in the same cycle, as well as self-targeted raises. The random stimulus draws indices across the full index range, and the directed cases set up coalesced senders and same-cycle collisions on purpose.

// File: rtl/xdb_pkg.sv
package xdb_pkg;
  typedef enum logic [1:0] {
    OP_RAISE = 2'd0,
    OP_PEEK  = 2'd1,
    OP_WHO   = 2'd2,
    OP_CLEAR = 2'd3
  } xdb_op_e;
endpackage

// File: rtl/xdb_cmd_decode.sv
module xdb_cmd_decode #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic          valid,
  input  logic [1:0]    op,
  input  logic [IW-1:0] idx,
  input  logic [IW-1:0] src,
  output logic [N*N-1:0] set_m,
  output logic [N*N-1:0] clr_m
);
  import xdb_pkg::*;

  // bit r*N+s : receiver r, sender s
  always_comb begin
    set_m = '0;
    clr_m = '0;
    for (int r = 0; r < N; r++) begin
      for (int s = 0; s < N; s++) begin
        if (valid && xdb_op_e'(op) == OP_RAISE && idx == IW'(r) &&
            src == IW'(s) && r != s)
          set_m[r*N+s] = 1'b1;
        if (valid && xdb_op_e'(op) == OP_CLEAR && src == IW'(r) &&
            idx == IW'(s))
          clr_m[r*N+s] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/xdb_pend_matrix.sv
module xdb_pend_matrix #(
  parameter int N  = 4,
  parameter int NP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NP*N*N-1:0] set_all,
  input  logic [NP*N*N-1:0] clr_all,
  output logic [N*N-1:0]    pend_q,
  output logic [N-1:0]      irq
);
  logic [N*N-1:0] set_or, clr_or;

  always_comb begin
    set_or = '0;
    clr_or = '0;
    for (int p = 0; p < NP; p++) begin
      set_or |= set_all[p*N*N +: N*N];
      clr_or |= clr_all[p*N*N +: N*N];
    end
  end

  // raise takes priority over clear on the same bit
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (pend_q & ~clr_or) | set_or;
  end

  always_comb begin
    for (int r = 0; r < N; r++) irq[r] = |pend_q[r*N +: N];
  end
endmodule

// File: rtl/xdb_readback.sv
module xdb_readback #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           valid,
  input  logic [1:0]     op,
  input  logic [IW-1:0]  idx,
  input  logic [IW-1:0]  src,
  input  logic [N*N-1:0] pend,
  output logic [N-1:0]   rdata
);
  import xdb_pkg::*;

  logic [N-1:0] row_idx, row_src;

  always_comb begin
    row_idx = '0;
    row_src = '0;
    for (int r = 0; r < N; r++) begin
      if (idx == IW'(r)) row_idx = pend[r*N +: N];
      if (src == IW'(r)) row_src = pend[r*N +: N];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (valid && xdb_op_e'(op) == OP_PEEK) begin
      rdata <= '0;
      rdata[0] <= |row_idx;
    end else if (valid && xdb_op_e'(op) == OP_WHO) begin
      rdata <= row_src;
    end
  end
endmodule

// File: rtl/xcore_doorbell.sv
module xcore_doorbell #(
  parameter int N  = 4,
  parameter int NP = 2,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NP-1:0]    cmd_valid,
  input  logic [2*NP-1:0]  cmd_op,
  input  logic [IW*NP-1:0] cmd_idx,
  input  logic [IW*NP-1:0] cmd_src,
  output logic [N*NP-1:0]  rdata,
  output logic [N-1:0]     irq_out
);
  localparam int MB = N * N;

  logic [NP*MB-1:0] set_all, clr_all;
  logic [MB-1:0]    pend_q;

  for (genvar p = 0; p < NP; p++) begin : g_port
    xdb_cmd_decode #(.N(N), .IW(IW)) u_dec (
      .valid (cmd_valid[p]),
      .op    (cmd_op[2*p +: 2]),
      .idx   (cmd_idx[IW*p +: IW]),
      .src   (cmd_src[IW*p +: IW]),
      .set_m (set_all[MB*p +: MB]),
      .clr_m (clr_all[MB*p +: MB])
    );
    xdb_readback #(.N(N), .IW(IW)) u_rb (
      .clk   (clk),
      .rst   (rst),
      .valid (cmd_valid[p]),
      .op    (cmd_op[2*p +: 2]),
      .idx   (cmd_idx[IW*p +: IW]),
      .src   (cmd_src[IW*p +: IW]),
      .pend  (pend_q),
      .rdata (rdata[N*p +: N])
    );
  end

  xdb_pend_matrix #(.N(N), .NP(NP)) u_mat (
    .clk     (clk),
    .rst     (rst),
    .set_all (set_all),
    .clr_all (clr_all),
    .pend_q  (pend_q),
    .irq     (irq_out)
  );
endmodule

// File: rtl/xdb_checker.sv
module xdb_checker #(
  parameter int N  = 4,
  parameter int NP = 2,
  parameter int IW = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [NP-1:0]    cmd_valid,
  input logic [2*NP-1:0]  cmd_op,
  input logic [IW*NP-1:0] cmd_idx,
  input logic [IW*NP-1:0] cmd_src,
  input logic [N*NP-1:0]  rdata,
  input logic [N-1:0]     irq_out,
  input logic [N*N-1:0]   pend
);
  logic [N*N-1:0] want_set, want_clr;
  logic [N-1:0]   row_clr;
  logic [N*NP-1:0] src_row, idx_row;
  logic [NP-1:0]  is_who, is_peek;

  always_comb begin
    want_set = '0;
    want_clr = '0;
    src_row  = '0;
    idx_row  = '0;
    for (int p = 0; p < NP; p++) begin
      is_who[p]  = cmd_valid[p] && cmd_op[2*p +: 2] == 2'd2;
      is_peek[p] = cmd_valid[p] && cmd_op[2*p +: 2] == 2'd1;
      for (int r = 0; r < N; r++) begin
        if (cmd_src[IW*p +: IW] == IW'(r)) src_row[N*p +: N] = pend[r*N +: N];
        if (cmd_idx[IW*p +: IW] == IW'(r)) idx_row[N*p +: N] = pend[r*N +: N];
        for (int s = 0; s < N; s++) begin
          if (cmd_valid[p] && cmd_op[2*p +: 2] == 2'd0 && r != s &&
              cmd_idx[IW*p +: IW] == IW'(r) && cmd_src[IW*p +: IW] == IW'(s))
            want_set[r*N+s] = 1'b1;
          if (cmd_valid[p] && cmd_op[2*p +: 2] == 2'd3 &&
              cmd_src[IW*p +: IW] == IW'(r) && cmd_idx[IW*p +: IW] == IW'(s))
            want_clr[r*N+s] = 1'b1;
        end
      end
    end
    for (int r = 0; r < N; r++) row_clr[r] = |want_clr[r*N +: N];
  end

  for (genvar b = 0; b < N*N; b++) begin : g_bit
    p_raise_wins_r8: assert property (@(posedge clk) disable iff (rst)
      want_set[b] |=> pend[b]);
    p_rise_from_raise_r1: assert property (@(posedge clk) disable iff (rst)
      $rose(pend[b]) |-> $past(want_set[b]));
    p_fall_from_clear_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(pend[b]) |-> $past(want_clr[b] && !want_set[b]));
  end

  for (genvar r = 0; r < N; r++) begin : g_core
    p_irq_drop_r6: assert property (@(posedge clk) disable iff (rst)
      $fell(irq_out[r]) |-> $past(row_clr[r]));
    p_irq_rise_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(irq_out[r]) |-> $past(|want_set[r*N +: N]));
  end

  for (genvar p = 0; p < NP; p++) begin : g_rb
    p_who_value_r4: assert property (@(posedge clk) disable iff (rst)
      is_who[p] |=> rdata[N*p +: N] == $past(src_row[N*p +: N]));
    p_peek_value_r3: assert property (@(posedge clk) disable iff (rst)
      is_peek[p] |=> rdata[N*p +: N] == {{(N-1){1'b0}}, $past(|idx_row[N*p +: N])});
    p_rb_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !(is_who[p] || is_peek[p]) |=> $stable(rdata[N*p +: N]));
  end
endmodule

bind xcore_doorbell xdb_checker #(.N(N), .NP(NP), .IW(IW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_idx   (cmd_idx),
  .cmd_src   (cmd_src),
  .rdata     (rdata),
  .irq_out   (irq_out),
  .pend      (pend_q)
);

// File: tb/sim_xcore_doorbell.sv
module sim_xcore_doorbell;
  localparam int N  = 4;
  localparam int NP = 2;
  localparam int IW = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NP-1:0]    cmd_valid = '0;
  logic [2*NP-1:0]  cmd_op = '0;
  logic [IW*NP-1:0] cmd_idx = '0;
  logic [IW*NP-1:0] cmd_src = '0;
  logic [N*NP-1:0]  rdata;
  logic [N-1:0]     irq_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [N*N-1:0]  mdl = '0;
  logic [N*NP-1:0] exp_rd = '0;

  always #2 clk = ~clk;

  xcore_doorbell #(.N(N), .NP(NP), .IW(IW)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_src(cmd_src), .rdata(rdata), .irq_out(irq_out)
  );

  function automatic logic [N-1:0] row_of(logic [N*N-1:0] m, int r);
    return m[r*N +: N];
  endfunction

  function automatic logic [N-1:0] irq_of(logic [N*N-1:0] m);
    logic [N-1:0] v;
    for (int r = 0; r < N; r++) v[r] = |m[r*N +: N];
    return v;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic put(int p, int op, int idx, int src);
    cmd_valid[p] = 1'b1;
    cmd_op[2*p +: 2] = 2'(op);
    cmd_idx[IW*p +: IW] = IW'(idx);
    cmd_src[IW*p +: IW] = IW'(src);
  endtask

  // apply queued commands for one cycle and compare against the model
  task automatic step(string req);
    logic [N*N-1:0] setm, clrm;
    setm = '0;
    clrm = '0;
    for (int p = 0; p < NP; p++) begin
      if (cmd_valid[p]) begin
        int op, ix, sr;
        op = int'(cmd_op[2*p +: 2]);
        ix = int'(cmd_idx[IW*p +: IW]);
        sr = int'(cmd_src[IW*p +: IW]);
        case (op)
          0: if (ix != sr) setm[ix*N+sr] = 1'b1;
          1: exp_rd[N*p +: N] = {{(N-1){1'b0}}, |row_of(mdl, ix)};
          2: exp_rd[N*p +: N] = row_of(mdl, sr);
          default: clrm[sr*N+ix] = 1'b1;
        endcase
      end
    end
    mdl = (mdl & ~clrm) | setm;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = '0;
    check({req, " irq"}, 32'(irq_out), 32'(irq_of(mdl)));
    check({req, " rdata"}, 32'(rdata), 32'(exp_rd));
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 reset irq", 32'(irq_out), 32'd0);
    check("R9 reset rdata", 32'(rdata), 32'd0);

    put(0, 0, 0, 0); step("R1 self raise");
    put(1, 0, 3, 3); step("R1 self raise");
    put(0, 0, 2, 1); put(1, 0, 2, 3); step("R10 R2 coalesce");
    check("R10 single line", 32'(irq_out), 32'b0100);
    put(0, 2, 0, 2); step("R4 who");
    check("R4 mask", 32'(rdata[3:0]), 32'b1010);
    put(1, 1, 2, 0); step("R3 peek busy");
    check("R3 value", 32'(rdata[7:4]), 32'd1);
    put(1, 1, 0, 2); step("R3 peek idle");
    put(0, 0, 2, 1); step("R7 re-raise");
    put(0, 0, 1, 0); step("R9 hold rdata");
    put(0, 3, 1, 2); step("R5 R6 partial clear");
    check("R6 still high", 32'(irq_out[2]), 32'd1);
    put(0, 2, 0, 2); step("R5 remaining");
    check("R5 mask", 32'(rdata[3:0]), 32'b1000);
    put(0, 0, 2, 3); put(1, 3, 3, 2); step("R8 raise beats clear");
    check("R8 kept", 32'(irq_out[2]), 32'd1);
    put(1, 3, 3, 2); step("R6 last clear");
    check("R6 dropped", 32'(irq_out[2]), 32'd0);

    for (int i = 0; i < 400; i++) begin
      for (int p = 0; p < NP; p++)
        if ($urandom_range(3) != 0)
          put(p, int'($urandom_range(3)), int'($urandom_range(N-1)),
              int'($urandom_range(N-1)));
      step("R2 R5 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule